// File: doc/BRIEF.md
# Digit Scan and Capture Strobe Generator

This block walks five digit-select lines from the most significant digit down to the least significant one. While a digit is selected, its BCD value appears on a shared four-bit bus. It is meant to sit behind a converter's result latches. A one-cycle end-of-conversion pulse captures the digit values and the overrange flag, and then starts a fresh scan.

On the first pass after a good result, the block drops an active-low capture strobe once in the middle of every digit slot, so that an external latch or serial transmitter can collect all five digits. The strobe is low for only the clock's low half. The first slot lasts one cycle longer than the others, and its strobe is one cycle later. After that first pass the scan keeps cycling to refresh a display, but it issues no more strobes.

An overrange result gets a single pass with no strobes, after which every select line goes low. An end-of-conversion pulse that arrives mid-scan abandons the current pass and starts over.

Top module: `digit_scan_strobe`

## Requirements
- R1: After reset and before the first end-of-conversion pulse, every bit of `digit_sel` is 0, `bcd_o` is 0 and `strobe_n` is 1.
- R2: An end-of-conversion pulse (`eoc_i` high at a rising edge) without overrange selects the most significant digit (`digit_sel[4]`) from the next cycle, for exactly 201 cycles.
- R3: After the first slot, `digit_sel[3]`, `digit_sel[2]`, `digit_sel[1]` and `digit_sel[0]` follow in that order, each for exactly 200 cycles.
- R4: During the first pass, `strobe_n` goes low exactly once per slot, only while `clk` is low. Number the cycles of a slot from 0. The low pulse falls in cycle 101 of the 201-cycle slot and in cycle 100 of each 200-cycle slot.
- R5: After the least significant slot, the scan repeats from `digit_sel[4]` with 200-cycle slots and no strobe until the next end-of-conversion pulse.
- R6: `bcd_o` shows digit k of the value captured at the end-of-conversion pulse while `digit_sel[k]` is high. Digit k sits at `digits_i[4k+3:4k]`, with k=0 the least significant. Changes on `digits_i` after the pulse have no effect on the output.
- R7: If `ovr_i` is high with the pulse, the block makes one pass (201, then 200 cycles per slot) with no strobe. Then all selects go low and `bcd_o` is 0 until the next pulse.
- R8: A pulse that arrives mid-scan ends the current slot at once and restarts at `digit_sel[4]` with a 201-cycle slot and a new set of five strobes.
- R9: At most one `digit_sel` bit is high at any time, and exactly one is high while scanning.
- R10: `bcd_o` changes only at a slot boundary or after an end-of-conversion pulse, never inside a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its low phase shapes the strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoc_i | input | 1 | One-cycle end-of-conversion pulse |
| ovr_i | input | 1 | Overrange flag, sampled with `eoc_i` |
| digits_i | input | 20 | Five BCD digits, digit 0 least significant in the low nibble |
| digit_sel | output | 5 | One-hot digit select, bit 4 most significant |
| bcd_o | output | 4 | BCD value of the selected digit |
| strobe_n | output | 1 | Active-low half-cycle capture strobe |

## Verification
The bench builds the block with its default parameters: five digits, a 200-cycle base slot, a one-cycle first-slot extension and a mid-slot strobe. At these values the 201-cycle first slot, the offset from strobe 101 to strobe 100, and the full repeat pass all occur within a few thousand cycles, so every slot length and strobe position is compared exactly.

The stimulus covers these cases:
- a long run into the strobe-free repeat pass;
- a restart in the middle of a slot, before that slot's strobe;
- a restart landing exactly on a pass boundary;
- an overrange pass that falls idle.

// File: rtl/dscan_pkg.sv
package dscan_pkg;

  // Length in cycles of a digit slot; the first slot after a capture is longer.
  function automatic int unsigned slot_cycles(input logic first,
                                              input int unsigned base,
                                              input int unsigned extra);
    return first ? base + extra : base;
  endfunction

  // Cycle index inside a slot at which the capture strobe fires.
  function automatic int unsigned strobe_point(input logic first,
                                               input int unsigned half,
                                               input int unsigned extra);
    return first ? half + extra : half;
  endfunction

endpackage

// File: rtl/dscan_slot_timer.sv
module dscan_slot_timer
  import dscan_pkg::*;
#(
  parameter int unsigned SLOT_BASE   = 200,
  parameter int unsigned FIRST_EXTRA = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic first,
  output logic slot_end,
  output logic mid_hit
);
  localparam int unsigned MID = SLOT_BASE / 2;
  localparam int unsigned CW  = $clog2(SLOT_BASE + FIRST_EXTRA + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last_idx;
  logic [CW-1:0] fire_idx;

  assign last_idx = CW'(slot_cycles(first, SLOT_BASE, FIRST_EXTRA) - 1);
  assign fire_idx = CW'(strobe_point(first, MID, FIRST_EXTRA));
  assign slot_end = run && (cnt == last_idx);
  assign mid_hit  = run && (cnt == fire_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (restart || slot_end || !run) cnt <= '0;
    else                                  cnt <= cnt + CW'(1);
  end

  // R3
  cnt_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= last_idx);
endmodule

// File: rtl/dscan_sequencer.sv
module dscan_sequencer #(
  parameter int unsigned NUM_DIGITS = 5,
  localparam int unsigned IW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eoc,
  input  logic          ovr,
  input  logic          slot_end,
  output logic          active,
  output logic          first,
  output logic          armed,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] TOP = IW'(NUM_DIGITS - 1);

  logic ovr_run;
  logic last_slot;

  assign last_slot = slot_end && (idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      first   <= 1'b0;
      armed   <= 1'b0;
      ovr_run <= 1'b0;
      idx     <= TOP;
    end else if (eoc) begin
      active  <= 1'b1;
      first   <= 1'b1;
      armed   <= !ovr;
      ovr_run <= ovr;
      idx     <= TOP;
    end else if (active && slot_end) begin
      first <= 1'b0;
      if (idx == '0) begin
        armed <= 1'b0;
        idx   <= TOP;
        if (ovr_run) active <= 1'b0;
      end else begin
        idx <= idx - IW'(1);
      end
    end
  end

  // R2
  restart_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !ovr) |=> (active && first && armed && idx == TOP));
  // R3
  digit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && slot_end && !eoc && idx != '0) |=> (idx == $past(idx) - IW'(1)));
  // R5
  armed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && last_slot && !eoc) |=> !armed);
  // R7
  ovr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_run && active && last_slot && !eoc) |=> !active);
endmodule

// File: rtl/dscan_strobe_gate.sv
module dscan_strobe_gate #(
  parameter int unsigned NUM_DIGITS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eoc,
  input  logic mid_hit,
  input  logic armed,
  output logic strobe_n
);
  localparam int unsigned PW = $clog2(NUM_DIGITS + 2);

  logic          fire;
  logic [PW-1:0] pulses;

  assign fire     = mid_hit && armed;
  // Low only in the low phase of the clock of the firing cycle.
  assign strobe_n = ~(fire & ~clk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pulses <= '0;
    else if (eoc)  pulses <= '0;
    else if (fire) pulses <= pulses + PW'(1);
  end

  // R4
  strobe_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (pulses < PW'(NUM_DIGITS)));
endmodule

// File: rtl/digit_scan_strobe.sv
module digit_scan_strobe #(
  parameter int unsigned NUM_DIGITS  = 5,
  parameter int unsigned SLOT_BASE   = 200,
  parameter int unsigned FIRST_EXTRA = 1,
  localparam int unsigned BCD_W = 4,
  localparam int unsigned DW    = NUM_DIGITS * BCD_W,
  localparam int unsigned IW    = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  eoc_i,
  input  logic                  ovr_i,
  input  logic [DW-1:0]         digits_i,
  output logic [NUM_DIGITS-1:0] digit_sel,
  output logic [BCD_W-1:0]      bcd_o,
  output logic                  strobe_n
);
  logic          active;
  logic          first;
  logic          armed;
  logic [IW-1:0] idx;
  logic          slot_end;
  logic          mid_hit;
  logic [DW-1:0] held;

  dscan_sequencer #(.NUM_DIGITS(NUM_DIGITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .eoc(eoc_i), .ovr(ovr_i), .slot_end(slot_end),
    .active(active), .first(first), .armed(armed), .idx(idx));

  dscan_slot_timer #(.SLOT_BASE(SLOT_BASE), .FIRST_EXTRA(FIRST_EXTRA)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(active), .restart(eoc_i), .first(first),
    .slot_end(slot_end), .mid_hit(mid_hit));

  dscan_strobe_gate #(.NUM_DIGITS(NUM_DIGITS)) u_stb (
    .clk(clk), .rst_n(rst_n), .eoc(eoc_i), .mid_hit(mid_hit), .armed(armed),
    .strobe_n(strobe_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held <= '0;
    else if (eoc_i) held <= digits_i;
  end

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_sel
    assign digit_sel[g] = active && (idx == IW'(g));
  end

  always_comb begin
    bcd_o = '0;
    if (active) bcd_o = held[int'(idx) * BCD_W +: BCD_W];
  end

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(digit_sel) && (!active || $countones(digit_sel) == 1));
  // R10
  bcd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoc_i && !slot_end) |=> $stable(bcd_o));
endmodule

// File: tb/sim_digit_scan_strobe.sv
`timescale 1ns/1ps
module sim_digit_scan_strobe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eoc = 1'b0;
  logic        ovr = 1'b0;
  logic [19:0] digits = '0;
  logic [4:0]  sel;
  logic [3:0]  bcd;
  logic        strobe_n;

  always #2 clk = ~clk;

  digit_scan_strobe u0 (
    .clk(clk), .rst_n(rst_n), .eoc_i(eoc), .ovr_i(ovr), .digits_i(digits),
    .digit_sel(sel), .bcd_o(bcd), .strobe_n(strobe_n));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit mon_on = 0;
  int q_sel[$], q_bcd[$], q_len[$], q_nstb[$], q_pos[$], q_tag[$];

  function automatic string tag_req(input int t);
    case (t)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      3: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected outputs in cycle c after the capture edge.
  task automatic model(input logic [19:0] dg, input bit ov, input int c,
                       output int e_sel, output int e_bcd, output bit e_stb,
                       output int s, output int pos);
    if (c < 201) begin s = 0; pos = c; end
    else begin s = 1 + (c - 201) / 200; pos = (c - 201) % 200; end
    if (ov && s >= 5) begin
      e_sel = 0; e_bcd = 0; e_stb = 0;
    end else begin
      int d = 4 - (s % 5);
      e_sel = 1 << d;
      e_bcd = int'((dg >> (4 * d)) & 20'hF);
      e_stb = !ov && s < 5 && pos == ((s == 0) ? 101 : 100);
    end
  endtask

  task automatic push(input int a, input int b, input int l, input int n,
                      input int p, input int t);
    q_sel.push_back(a); q_bcd.push_back(b); q_len.push_back(l);
    q_nstb.push_back(n); q_pos.push_back(p); q_tag.push_back(t);
  endtask

  // Driver: pulse end-of-conversion, queue expected slots for ncyc cycles.
  task automatic conv(input logic [19:0] dg, input bit ov, input int ncyc,
                      input bit cut);
    int rs = 0, rl = 0, rb = 0, rn = 0, rp = -1, rt = 0, rfull = 0;
    for (int c = 0; c < ncyc; c++) begin
      int es, eb, s, pos;
      bit st;
      model(dg, ov, c, es, eb, st, s, pos);
      if (es != rs) begin
        if (rs != 0) push(rs, rb, rl, rn, rp, rt);
        rs = es; rl = 0; rb = eb; rn = 0; rp = -1;
        rfull = (s == 0) ? 201 : 200;
        rt = ov ? 4 : (s == 0) ? 0 : (s < 5) ? 1 : 2;
      end
      if (st) begin rn++; rp = rl; end
      rl++;
    end
    if (cut && rs != 0) push(rs, rb, rl, rn, rp, (rl < rfull) ? 3 : rt);
    @(posedge clk); #1; eoc = 1; ovr = ov; digits = dg;
    @(posedge clk); #1; eoc = 0; ovr = 0; digits = ~dg;   // R6 late change
    repeat (ncyc - 2) @(posedge clk);
  endtask

  // Monitor: rebuild slots from the ports and compare with the queue.
  int  cur_sel = 0, cur_len = 0, cur_bcd = 0, cur_n = 0, cur_p = -1;
  bit  bcd_moved = 0;
  int  stray = 0, multi = 0;

  task automatic close_run();
    int es, eb, el, en, ep, et;
    if (q_sel.size() == 0) begin
      check(0, "R3", "unexpected slot select", cur_sel, 0);
      return;
    end
    es = q_sel.pop_front(); eb = q_bcd.pop_front(); el = q_len.pop_front();
    en = q_nstb.pop_front(); ep = q_pos.pop_front(); et = q_tag.pop_front();
    check(cur_sel == es, tag_req(et), "slot select", cur_sel, es);
    check(cur_len == el, tag_req(et), "slot length", cur_len, el);
    check(cur_n == en, (et == 4) ? "R7" : (et == 2) ? "R5" : "R4",
          "strobe count", cur_n, en);
    check(cur_p == ep, "R4", "strobe position", cur_p, ep);
    check(cur_bcd == eb, "R6", "bcd value", cur_bcd, eb);
    check(!bcd_moved, "R10", "bcd held in slot", int'(bcd_moved), 0);
  endtask

  initial forever begin
    @(posedge clk); #3;
    if (mon_on) begin
      if ($countones(sel) > 1) multi++;
      if (int'(sel) != cur_sel) begin
        if (cur_sel != 0) close_run();
        cur_sel = int'(sel); cur_len = 0; cur_bcd = int'(bcd);
        cur_n = 0; cur_p = -1; bcd_moved = 0;
      end
      if (int'(bcd) != cur_bcd) bcd_moved = 1;
      if (!strobe_n) begin
        if (sel == '0) stray++;
        else begin cur_n++; cur_p = cur_len; end
      end
      cur_len++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #3;
      check(sel == '0, "R1", "idle select", int'(sel), 0);
      check(bcd == '0 && strobe_n, "R1", "idle bcd/strobe",
            int'({bcd, strobe_n}), 1);
    end
    mon_on = 1;
    conv(20'h12345, 0, 2501, 1);  // R2 R3 R4 R5, cut inside repeat pass
    conv(20'h67890, 0, 651, 1);   // R8 restart before mid-slot strobe
    conv(20'h90817, 0, 1001, 1);  // restart exactly at pass boundary
    conv(20'h55432, 1, 1021, 0);  // R7 overrange pass then idle
    repeat (40) @(posedge clk);
    #3;
    check(sel == '0, "R7", "select after overrange pass", int'(sel), 0);
    check(bcd == '0, "R7", "bcd after overrange pass", int'(bcd), 0);
    check(q_sel.size() == 0, "R3", "slots left unseen", q_sel.size(), 0);
    check(stray == 0, "R5", "strobes outside slots", stray, 0);
    check(multi == 0, "R9", "cycles with several selects", multi, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule